// File: doc/BRIEF.md
# Sound Generator Host Bus Front End

This block is the host-facing register interface of a three-channel programmable sound generator. Three bus control lines select one of four bus modes: idle, address latch, read and write. The block holds sixteen 8-bit registers. A selected-index register picks which of them the host reads or writes. Two of the registers double as general-purpose I/O ports. Each port shows its register on an output. An external agent can overwrite either port register by presenting a value with a load strobe.

Bus behaviour is level-sensitive. The decoded mode is not a one-shot strobe. Its action is applied again on every clock for as long as the control lines hold that mode. A held write follows changes on the data input. A held latch follows the index on the data input. A held read shows, on the data output, any register change made by a port load, without a new control transition.

Top module: `psg_bus_if`

## Requirements
- R1: The control lines {bus_dir_i, bus_c2_i, bus_c1_i} decode to a mode as follows. 3'b110 is write. 3'b011 is read. 3'b100, 3'b001 and 3'b111 are address latch. 3'b000, 3'b010 and 3'b101 are idle.
- R2: In address latch mode, the selected index becomes data_i[3:0] on the next clock edge. Bits data_i[7:4] have no effect.
- R3: In write mode, data_i is stored into the selected register on the next clock edge.
- R4: In read mode, data_o takes the selected register's contents ORed with a fixed mask on the next clock edge. The mask is 8'hF0 for registers 1, 3, 5 and 13. It is 8'hE0 for registers 6, 8, 9 and 10. It is 8'h00 for all other registers.
- R5: port_a_o always shows register 14 and port_b_o always shows register 15.
- R6: While port_a_ld_i or port_b_ld_i is high, register 14 or 15 respectively takes port_a_i or port_b_i on each clock edge. In the same cycle, a port load wins over a host write to that register.
- R7: A held mode is applied again on every clock. Changes to data_i take effect in a held write or latch one edge later. A change made by a port load appears on data_o in a held read two edges after the load input changes.
- R8: In idle mode, data_o holds its last value. The registers and the selected index change only through port loads.
- R9: Asserting rst_ni low asynchronously clears all registers, the selected index and data_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_dir_i | input | 1 | Bus control line, direction |
| bus_c2_i | input | 1 | Bus control line 2 |
| bus_c1_i | input | 1 | Bus control line 1 |
| data_i | input | 8 | Host data / index input |
| data_o | output | 8 | Host read data |
| port_a_i | input | 8 | External value for port A |
| port_a_ld_i | input | 1 | Load port_a_i into register 14 |
| port_b_i | input | 8 | External value for port B |
| port_b_ld_i | input | 1 | Load port_b_i into register 15 |
| port_a_o | output | 8 | Register 14 contents |
| port_b_o | output | 8 | Register 15 contents |

## Verification
The assertions check four things on every cycle. data_o and both port outputs stay stable in idle mode when no port load is active. A port load lands on its port output one edge later. A latch loads the low data nibble into the index. Reads of a masked register force the masked high bits. The bench scenarios cover what needs a sequence of bus operations:
- the full eight-way control decode
- the per-register masks
- load-over-write priority
- data changes followed live under a held write or latch
- port changes seen on data_o during a held read

// File: rtl/psg_bus_pkg.sv
package psg_bus_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_LATCH = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } bus_mode_e;

  // bits forced high on readback for unimplemented register bits
  function automatic logic [DATA_W-1:0] rd_mask(input int unsigned idx);
    case (idx)
      1, 3, 5, 13:   rd_mask = 8'hF0;
      6, 8, 9, 10:   rd_mask = 8'hE0;
      default:       rd_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/psg_mode_dec.sv
module psg_mode_dec
  import psg_bus_pkg::*;
(
  input  logic      dir_i,
  input  logic      c2_i,
  input  logic      c1_i,
  output bus_mode_e mode_o
);
  always_comb begin
    unique case ({dir_i, c2_i, c1_i})
      3'b110:                 mode_o = MODE_WRITE;
      3'b011:                 mode_o = MODE_READ;
      3'b100, 3'b001, 3'b111: mode_o = MODE_LATCH;
      default:                mode_o = MODE_IDLE;
    endcase
  end
endmodule

// File: rtl/psg_reg_file.sv
module psg_reg_file #(
  parameter int unsigned DW      = 8,
  parameter int unsigned NREGS   = 16,
  parameter int unsigned PORT_A  = 14,
  parameter int unsigned PORT_B  = 15,
  localparam int unsigned AW     = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_idx_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic                      pa_ld_i,
  input  logic [DW-1:0]             pa_data_i,
  input  logic                      pb_ld_i,
  input  logic [DW-1:0]             pb_data_i,
  output logic [NREGS-1:0][DW-1:0]  regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic          host_hit;
    logic          port_hit;
    logic [DW-1:0] port_val;

    assign host_hit = wr_en_i && (wr_idx_i == AW'(g));

    if (g == PORT_A) begin : g_pa
      assign port_hit = pa_ld_i;
      assign port_val = pa_data_i;
    end else if (g == PORT_B) begin : g_pb
      assign port_hit = pb_ld_i;
      assign port_val = pb_data_i;
    end else begin : g_plain
      assign port_hit = 1'b0;
      assign port_val = '0;
    end

    // external port load has priority over host write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       regs_o[g] <= '0;
      else if (port_hit) regs_o[g] <= port_val;
      else if (host_hit) regs_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/psg_rd_path.sv
module psg_rd_path
  import psg_bus_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NREGS = 16,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_en_i,
  input  logic [AW-1:0]            rd_idx_i,
  input  logic [NREGS-1:0][DW-1:0] regs_i,
  output logic [DW-1:0]            data_o
);
  logic [NREGS-1:0][DW-1:0] mask_tbl;

  for (genvar g = 0; g < NREGS; g++) begin : g_mask
    assign mask_tbl[g] = DW'(rd_mask(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (rd_en_i) data_o <= regs_i[rd_idx_i] | mask_tbl[rd_idx_i];
  end
endmodule

// File: rtl/psg_bus_if.sv
module psg_bus_if
  import psg_bus_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned NREGS  = NUM_REGS,
  parameter int unsigned PORT_A = 14,
  parameter int unsigned PORT_B = 15,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_dir_i,
  input  logic          bus_c2_i,
  input  logic          bus_c1_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  input  logic [DW-1:0] port_a_i,
  input  logic          port_a_ld_i,
  input  logic [DW-1:0] port_b_i,
  input  logic          port_b_ld_i,
  output logic [DW-1:0] port_a_o,
  output logic [DW-1:0] port_b_o
);
  bus_mode_e                mode;
  logic [AW-1:0]            sel_q;
  logic [NREGS-1:0][DW-1:0] regs;

  psg_mode_dec u_dec (
    .dir_i  (bus_dir_i),
    .c2_i   (bus_c2_i),
    .c1_i   (bus_c1_i),
    .mode_o (mode)
  );

  // index re-latched every cycle while latch mode is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sel_q <= '0;
    else if (mode == MODE_LATCH) sel_q <= data_i[AW-1:0];
  end

  psg_reg_file #(
    .DW(DW), .NREGS(NREGS), .PORT_A(PORT_A), .PORT_B(PORT_B)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (mode == MODE_WRITE),
    .wr_idx_i  (sel_q),
    .wr_data_i (data_i),
    .pa_ld_i   (port_a_ld_i),
    .pa_data_i (port_a_i),
    .pb_ld_i   (port_b_ld_i),
    .pb_data_i (port_b_i),
    .regs_o    (regs)
  );

  psg_rd_path #(.DW(DW), .NREGS(NREGS)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (mode == MODE_READ),
    .rd_idx_i (sel_q),
    .regs_i   (regs),
    .data_o   (data_o)
  );

  assign port_a_o = regs[PORT_A];
  assign port_b_o = regs[PORT_B];
endmodule

// File: rtl/psg_bus_chk.sv
module psg_bus_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_dir_i,
  input logic          bus_c2_i,
  input logic          bus_c1_i,
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] data_o,
  input logic [DW-1:0] port_a_i,
  input logic          port_a_ld_i,
  input logic [DW-1:0] port_b_i,
  input logic          port_b_ld_i,
  input logic [DW-1:0] port_a_o,
  input logic [DW-1:0] port_b_o,
  input logic [AW-1:0] sel_i
);
  logic [2:0] ctl;
  logic       is_idle, is_latch, is_read;
  assign ctl      = {bus_dir_i, bus_c2_i, bus_c1_i};
  assign is_idle  = (ctl == 3'b000) || (ctl == 3'b010) || (ctl == 3'b101);
  assign is_latch = (ctl == 3'b100) || (ctl == 3'b001) || (ctl == 3'b111);
  assign is_read  = (ctl == 3'b011);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_idle |=> $stable(data_o));

  // R8
  idle_port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_idle && !port_a_ld_i && !port_b_ld_i) |=> ($stable(port_a_o) && $stable(port_b_o)));

  // R6
  port_a_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_a_ld_i |=> (port_a_o == $past(port_a_i)));

  // R6
  port_b_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_b_ld_i |=> (port_b_o == $past(port_b_i)));

  // R2
  latch_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_latch |=> (sel_i == $past(data_i[AW-1:0])));

  // R4
  read_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_read && (sel_i == AW'(1))) |=> (data_o[DW-1:DW-4] == 4'hF));
endmodule

bind psg_bus_if psg_bus_chk #(.DW(DW), .AW(AW)) u_psg_bus_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_dir_i   (bus_dir_i),
  .bus_c2_i    (bus_c2_i),
  .bus_c1_i    (bus_c1_i),
  .data_i      (data_i),
  .data_o      (data_o),
  .port_a_i    (port_a_i),
  .port_a_ld_i (port_a_ld_i),
  .port_b_i    (port_b_i),
  .port_b_ld_i (port_b_ld_i),
  .port_a_o    (port_a_o),
  .port_b_o    (port_b_o),
  .sel_i       (sel_q)
);

// File: tb/psg_bus_if_bench.sv
module psg_bus_if_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_dir_i = 1'b0, bus_c2_i = 1'b0, bus_c1_i = 1'b0;
  logic [7:0] data_i = '0, port_a_i = '0, port_b_i = '0;
  logic       port_a_ld_i = 1'b0, port_b_ld_i = 1'b0;
  logic [7:0] data_o, port_a_o, port_b_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  psg_bus_if u_psg_bus_if (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_dir_i(bus_dir_i), .bus_c2_i(bus_c2_i), .bus_c1_i(bus_c1_i),
    .data_i(data_i), .data_o(data_o),
    .port_a_i(port_a_i), .port_a_ld_i(port_a_ld_i),
    .port_b_i(port_b_i), .port_b_ld_i(port_b_ld_i),
    .port_a_o(port_a_o), .port_b_o(port_b_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // 0 idle, 1 latch, 2 read, 3 write
  function automatic int mode_of(input logic [2:0] c);
    case (c)
      3'b110: return 3;
      3'b011: return 2;
      3'b100, 3'b001, 3'b111: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] mask_of(input int idx);
    if (idx == 1 || idx == 3 || idx == 5 || idx == 13) return 8'hF0;
    if (idx == 6 || idx == 8 || idx == 9 || idx == 10) return 8'hE0;
    return 8'h00;
  endfunction

  task automatic drive(input logic [2:0] c, input logic [7:0] d);
    @(negedge clk);
    {bus_dir_i, bus_c2_i, bus_c1_i} = c;
    data_i = d;
  endtask

  task automatic idle();
    drive(3'b000, data_i);
  endtask

  task automatic latch(input logic [7:0] d);
    drive(3'b100, d);
    idle();
  endtask

  task automatic wr(input logic [7:0] d);
    drive(3'b110, d);
    idle();
  endtask

  task automatic rd(output logic [7:0] v);
    drive(3'b011, data_i);
    @(negedge clk);
    v = data_o;
    {bus_dir_i, bus_c2_i, bus_c1_i} = 3'b000;
  endtask

  task automatic t_reset();
    check("R9 data_o", data_o, 8'h00);
    check("R9 port_a", port_a_o, 8'h00);
    check("R9 port_b", port_b_o, 8'h00);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    latch(8'h07); wr(8'h33);
    for (int c = 0; c < 8; c++) begin
      latch(8'h07); rd(v);
      latch(8'h02);
      drive(3'(c), 8'h07);
      idle();
      check($sformatf("R1 combo %0d immediate", c), data_o,
            (mode_of(3'(c)) == 2) ? 8'h00 : 8'h33);
      rd(v);
      check($sformatf("R1 combo %0d effect", c), v,
            (mode_of(3'(c)) == 1) ? 8'h33 :
            (mode_of(3'(c)) == 3) ? 8'h07 : 8'h00);
      latch(8'h02); wr(8'h00);
    end
  endtask

  task automatic t_latch_masks();
    logic [7:0] v;
    latch(8'hF5); wr(8'h0B);
    latch(8'h05); rd(v);
    check("R2 upper index bits ignored", v, 8'hFB);
    for (int i = 0; i < 16; i++) begin
      latch(8'(i)); wr(8'(i));
    end
    for (int i = 0; i < 16; i++) begin
      latch(8'(i)); rd(v);
      check($sformatf("R3/R4 reg %0d", i), v, 8'(i) | mask_of(i));
    end
  endtask

  task automatic t_ports();
    latch(8'h0E); wr(8'h3C);
    latch(8'h0F); wr(8'hC3);
    check("R5 port_a", port_a_o, 8'h3C);
    check("R5 port_b", port_b_o, 8'hC3);
  endtask

  task automatic t_live_read();
    latch(8'h0E);
    drive(3'b011, 8'h00);
    port_a_i = 8'h81; port_a_ld_i = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 live port A read", data_o, 8'h81);
    port_a_i = 8'h42;
    @(negedge clk); @(negedge clk);
    check("R7 live port A change", data_o, 8'h42);
    check("R6 port_a load", port_a_o, 8'h42);
    port_a_ld_i = 1'b0;
    idle();
    latch(8'h0F);
    drive(3'b011, 8'h00);
    port_b_i = 8'h5A; port_b_ld_i = 1'b1;
    @(negedge clk); @(negedge clk);
    port_b_ld_i = 1'b0;
    check("R7 live port B read", data_o, 8'h5A);
    idle();
  endtask

  task automatic t_live_write();
    logic [7:0] v;
    latch(8'h09);
    drive(3'b110, 8'h11);
    drive(3'b110, 8'h03);
    idle();
    rd(v);
    check("R7 held write follows data", v, 8'hE3);
    drive(3'b001, 8'h01);
    drive(3'b001, 8'h0C);
    idle();
    wr(8'h77);
    latch(8'h0C); rd(v);
    check("R7 held latch follows data", v, 8'h77);
  endtask

  task automatic t_priority();
    latch(8'h0F);
    @(negedge clk);
    {bus_dir_i, bus_c2_i, bus_c1_i} = 3'b110;
    data_i = 8'h55; port_b_i = 8'h66; port_b_ld_i = 1'b1;
    @(negedge clk);
    port_b_ld_i = 1'b0;
    {bus_dir_i, bus_c2_i, bus_c1_i} = 3'b000;
    check("R6 load beats host write", port_b_o, 8'h66);
  endtask

  task automatic t_idle();
    logic [7:0] v, a, b;
    latch(8'h0C); rd(v);
    a = port_a_o; b = port_b_o;
    drive(3'b000, 8'hA5);
    drive(3'b010, 8'h5A);
    drive(3'b101, 8'hFF);
    idle();
    check("R8 idle data_o hold", data_o, v);
    check("R8 idle port_a hold", port_a_o, a);
    check("R8 idle port_b hold", port_b_o, b);
    rd(v);
    check("R8 idle index and reg unchanged", v, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_decode();
    t_latch_masks();
    t_ports();
    t_live_read();
    t_live_write();
    t_priority();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule